// File: doc/BRIEF.md
# Write Delay Setting Encoder

This block turns a raw three-level write-delay setting into the packed word a write-timing control register expects. The setting has a group value, a coarse step and a fine phase. Each of the three is a small signed number, and the coarse step and the fine phase may sit outside their legal ranges. The block first carries and borrows between the three levels until the phase and the coarse step are in range. It then derives a 2-bit band code from the normalised coarse step. In the high-speed mode it also pins the phase to a fixed value in two places where it would otherwise cross a coarse-step boundary.

A training routine calls the block each time it moves its search point. That routine hands over the current register contents as a base word together with the raw setting. One cycle after the strobe the block returns the updated word, plus a flag that tells whether the group value ran out of range. A single mode input selects between the normal and high-speed clock cases. The mode changes the coarse wrap value, the band thresholds and whether the phase pinning applies.

Top module: `write_delay_encoder`

## Requirements
- R1: The fine phase wraps at 8. Each step of 8 above 7 carries one into the coarse step, and a negative phase borrows from the coarse step until the phase lies in 0..7.
- R2: The coarse step wraps at 11 when `fast_mode` is 0 and at 12 when `fast_mode` is 1. It carries into or borrows from the group value, so the encoded coarse step is always below the wrap value.
- R3: `overflow` is 1 exactly when the normalised group value is below 0 or above 3. The group field then holds the two low bits of the group value in two's complement.
- R4: Field layout of `reg_word`: coarse step in bits 31:28, fine phase in bits 26:24, group value in bits 19:18, band code in bits 17:16.
- R5: When `fast_mode` is 0, the band code is 2'b11 for a coarse step of 1 or less, 2'b01 for a coarse step above 6, and 2'b00 otherwise.
- R6: When `fast_mode` is 1, the band code is 2'b11 for a coarse step of 2 or less, 2'b01 for a coarse step above 9, and 2'b00 otherwise. The code 2'b10 never appears.
- R7: When `fast_mode` is 1, the encoded phase is forced to 4 in two cases: a normalised coarse step of 9 with phase 4..7, and a coarse step of 10 with phase 0..3. When `fast_mode` is 0 the phase is never altered.
- R8: `out_valid` is 1 in the cycle after each cycle with `in_valid` high, and 0 otherwise. `reg_word` and `overflow` update from the inputs sampled with that strobe.
- R9: Bits 27, 23:20 and 15:0 of `reg_word` copy `base_word` as sampled with the strobe. Without a strobe, `reg_word` and `overflow` hold their values whatever the other inputs do.
- R10: After a synchronous reset, `out_valid`, `overflow` and `reg_word` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: sample the setting and base word |
| fast_mode | input | 1 | 1 selects the high-speed clock case |
| grp_in | input | IN_W | Signed group value |
| crs_in | input | IN_W | Signed coarse step |
| phs_in | input | IN_W | Signed fine phase |
| base_word | input | 32 | Current register contents |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| reg_word | output | 32 | Packed register word |
| overflow | output | 1 | Normalised group value outside 0..3 |

## Verification
The bench builds the block with its default parameters: 6-bit signed inputs, wraps of 11 and 12, and thresholds 1/6 and 2/9. With 6-bit inputs a phase as low as -32 and a coarse step of 31 are reachable. Those values drive borrows and carries across several coarse wraps at once, and group values well beyond both ends of 0..3. The directed cases sit on each band threshold, on both pinning windows in both modes, and on single carries and borrows. Random settings and base words follow them.

// File: rtl/wde_pkg.sv
package wde_pkg;
  localparam int WORD_W   = 32;
  localparam int CRS_LSB  = 28;
  localparam int PHS_LSB  = 24;
  localparam int GRP_LSB  = 18;
  localparam int BAND_LSB = 16;
  // bits owned by the encoder; everything else comes from the base word
  localparam logic [WORD_W-1:0] FIELD_MASK = 32'hF70F_0000;

  typedef enum logic [1:0] {
    BAND_MID  = 2'b00,
    BAND_HIGH = 2'b01,
    BAND_LOW  = 2'b11
  } band_e;

  typedef struct packed {
    logic [3:0] crs;
    logic [2:0] phs;
    logic [1:0] grp;
    band_e      band;
  } wd_fields_t;
endpackage

// File: rtl/wde_normalize.sv
module wde_normalize #(
  parameter int IN_W     = 6,
  parameter int NRM_WRAP = 11,
  parameter int FST_WRAP = 12
) (
  input  logic                   fast_mode,
  input  logic signed [IN_W-1:0] grp_in,
  input  logic signed [IN_W-1:0] crs_in,
  input  logic signed [IN_W-1:0] phs_in,
  output logic [3:0]             crs_out,
  output logic [2:0]             phs_out,
  output logic [1:0]             grp_out,
  output logic                   grp_ovf
);
  localparam int SW = (IN_W + 2 > 6) ? IN_W + 2 : 6;
  localparam logic signed [SW-1:0] ONE_S   = 1;
  localparam logic signed [SW-1:0] ZERO_S  = 0;
  localparam logic signed [SW-1:0] GMAX_S  = 3;
  localparam logic signed [SW-1:0] NWRAP_S = NRM_WRAP;
  localparam logic signed [SW-1:0] FWRAP_S = FST_WRAP;

  logic signed [SW-1:0] carry_p, crs_sum, wrap_s, quo, rem, grp_sum;
  logic unused_hi;

  always_comb begin
    // phase level: floor division by 8 is an arithmetic shift
    carry_p = SW'(phs_in >>> 3);
    crs_sum = SW'(crs_in) + carry_p;
    // coarse level: floored division by the mode-dependent wrap
    wrap_s  = fast_mode ? FWRAP_S : NWRAP_S;
    quo     = crs_sum / wrap_s;
    rem     = crs_sum - quo * wrap_s;
    if (rem < ZERO_S) begin
      quo = quo - ONE_S;
      rem = rem + wrap_s;
    end
    grp_sum = SW'(grp_in) + quo;
    grp_ovf = (grp_sum < ZERO_S) || (grp_sum > GMAX_S);
    crs_out = rem[3:0];
    phs_out = phs_in[2:0];
    grp_out = grp_sum[1:0];
  end

  assign unused_hi = ^rem[SW-1:4];
endmodule

// File: rtl/wde_fieldmap.sv
module wde_fieldmap
  import wde_pkg::*;
#(
  parameter int NRM_LO  = 1,
  parameter int NRM_HI  = 6,
  parameter int FST_LO  = 2,
  parameter int FST_HI  = 9,
  parameter int PIN_CRS = 9,
  parameter int PIN_PHS = 4
) (
  input  logic       fast_mode,
  input  logic [3:0] crs,
  input  logic [2:0] phs,
  output band_e      band,
  output logic [2:0] phs_fix
);
  localparam logic [3:0] N_LO  = 4'(NRM_LO);
  localparam logic [3:0] N_HI  = 4'(NRM_HI);
  localparam logic [3:0] F_LO  = 4'(FST_LO);
  localparam logic [3:0] F_HI  = 4'(FST_HI);
  localparam logic [3:0] PIN_A = 4'(PIN_CRS);
  localparam logic [3:0] PIN_B = 4'(PIN_CRS + 1);
  localparam logic [2:0] PIN_P = 3'(PIN_PHS);

  logic [3:0] lo_th, hi_th;
  logic       pin_hit;

  always_comb begin
    lo_th = fast_mode ? F_LO : N_LO;
    hi_th = fast_mode ? F_HI : N_HI;
    if (crs <= lo_th)     band = BAND_LOW;
    else if (crs > hi_th) band = BAND_HIGH;
    else                  band = BAND_MID;
    // keep the phase off the coarse boundary in the high-speed case
    pin_hit = fast_mode && (((crs == PIN_A) && (phs >= PIN_P)) ||
                            ((crs == PIN_B) && (phs <  PIN_P)));
    phs_fix = pin_hit ? PIN_P : phs;
  end
endmodule

// File: rtl/write_delay_encoder.sv
module write_delay_encoder
  import wde_pkg::*;
#(
  parameter int IN_W     = 6,
  parameter int NRM_WRAP = 11,
  parameter int FST_WRAP = 12,
  parameter int NRM_LO   = 1,
  parameter int NRM_HI   = 6,
  parameter int FST_LO   = 2,
  parameter int FST_HI   = 9
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic                   fast_mode,
  input  logic signed [IN_W-1:0] grp_in,
  input  logic signed [IN_W-1:0] crs_in,
  input  logic signed [IN_W-1:0] phs_in,
  input  logic [WORD_W-1:0]      base_word,
  output logic                   out_valid,
  output logic [WORD_W-1:0]      reg_word,
  output logic                   overflow
);
  wd_fields_t        fld;
  logic [2:0]        phs_raw;
  logic              ovf_c;
  logic [WORD_W-1:0] word_c;

  wde_normalize #(.IN_W(IN_W), .NRM_WRAP(NRM_WRAP), .FST_WRAP(FST_WRAP)) u_norm (
    .fast_mode (fast_mode),
    .grp_in    (grp_in),
    .crs_in    (crs_in),
    .phs_in    (phs_in),
    .crs_out   (fld.crs),
    .phs_out   (phs_raw),
    .grp_out   (fld.grp),
    .grp_ovf   (ovf_c)
  );

  wde_fieldmap #(.NRM_LO(NRM_LO), .NRM_HI(NRM_HI), .FST_LO(FST_LO),
                 .FST_HI(FST_HI), .PIN_CRS(9), .PIN_PHS(4)) u_map (
    .fast_mode (fast_mode),
    .crs       (fld.crs),
    .phs       (phs_raw),
    .band      (fld.band),
    .phs_fix   (fld.phs)
  );

  always_comb begin
    word_c = base_word & ~FIELD_MASK;
    word_c[CRS_LSB  +: 4] = fld.crs;
    word_c[PHS_LSB  +: 3] = fld.phs;
    word_c[GRP_LSB  +: 2] = fld.grp;
    word_c[BAND_LSB +: 2] = fld.band;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      reg_word  <= '0;
      overflow  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        reg_word <= word_c;
        overflow <= ovf_c;
      end
    end
  end

  // R8: result appears exactly one cycle after each strobe
  a_r8_strobe_to_valid: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R9: no strobe means the word and the flag stay put
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(reg_word) && $stable(overflow)));
  // R9: untouched bits come straight from the sampled base word
  a_r9_passthru: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((reg_word & ~FIELD_MASK) == ($past(base_word) & ~FIELD_MASK)));
  // R2: encoded coarse step always below the wrap of the sampled mode
  a_r2_crs_below_wrap: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (reg_word[CRS_LSB +: 4] < ($past(fast_mode) ? 4'(FST_WRAP) : 4'(NRM_WRAP))));
  // R6: band code 2'b10 is never produced
  a_r6_band_legal: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (reg_word[BAND_LSB +: 2] != 2'b10));
  // R7: in the high-speed case coarse step 10 never carries a phase below 4
  a_r7_pin_upper: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fast_mode) |=>
      ((reg_word[CRS_LSB +: 4] != 4'd10) || (reg_word[PHS_LSB +: 3] >= 3'd4)));
  // R7: and coarse step 9 never carries a phase above 4
  a_r7_pin_lower: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fast_mode) |=>
      ((reg_word[CRS_LSB +: 4] != 4'd9) || (reg_word[PHS_LSB +: 3] <= 3'd4)));
endmodule

// File: tb/write_delay_encoder_tb_top.sv
`timescale 1ns/1ps
module write_delay_encoder_tb_top;
  localparam int IN_W = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic fast_mode = 1'b0;
  logic signed [IN_W-1:0] grp_in = '0, crs_in = '0, phs_in = '0;
  logic [31:0] base_word = '0;
  logic out_valid, overflow;
  logic [31:0] reg_word;

  always #10 clk = ~clk;

  write_delay_encoder #(.IN_W(IN_W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .fast_mode(fast_mode),
    .grp_in(grp_in), .crs_in(crs_in), .phs_in(phs_in), .base_word(base_word),
    .out_valid(out_valid), .reg_word(reg_word), .overflow(overflow));

  typedef struct {
    logic [31:0] word;
    logic        ovf;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          n_tests = 0;
  int          n_fail  = 0;
  logic [31:0] last_word = '0;
  logic        last_ovf  = 1'b0;
  bit          done = 1'b0;

  function automatic void ref_model(input int g, input int c, input int p, input bit fm,
                                    input logic [31:0] base,
                                    output logic [31:0] w, output logic ov);
    int wrap, total, den, q, r, cc, pp;
    logic [1:0] band;
    wrap  = fm ? 12 : 11;
    den   = wrap * 8;
    total = (g * wrap + c) * 8 + p;
    q = total / den;
    r = total - q * den;
    if (r < 0) begin q = q - 1; r = r + den; end
    cc = r / 8;
    pp = r % 8;
    ov = (q < 0) || (q > 3);
    if (fm && (((cc == 9) && (pp >= 4)) || ((cc == 10) && (pp < 4)))) pp = 4;
    if (cc <= (fm ? 2 : 1))      band = 2'b11;
    else if (cc > (fm ? 9 : 6))  band = 2'b01;
    else                         band = 2'b00;
    w = base & 32'h08F0_FFFF;
    w[31:28] = 4'(cc);
    w[26:24] = 3'(pp);
    w[19:18] = 2'(q);
    w[17:16] = band;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input string tag, input int g, input int c, input int p,
                       input bit fm, input logic [31:0] base);
    exp_t e;
    @(negedge clk);
    grp_in = IN_W'(g); crs_in = IN_W'(c); phs_in = IN_W'(p);
    fast_mode = fm; base_word = base; in_valid = 1'b1;
    ref_model(g, c, p, fm, base, e.word, e.ovf);
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      grp_in = IN_W'($urandom); crs_in = IN_W'($urandom); phs_in = IN_W'($urandom);
      base_word = $urandom; fast_mode = 1'($urandom);
    end
  endtask

  // monitor: compares each result against the queued expectation
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb_q.size() == 0) begin
        check("R8", "unexpected out_valid", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, "reg_word", reg_word, e.word);
        check(e.tag, "overflow", {31'd0, overflow}, {31'd0, e.ovf});
        last_word = e.word;
        last_ovf  = e.ovf;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "out_valid", {31'd0, out_valid}, 32'd0);
    check("R10", "reg_word", reg_word, 32'd0);
    check("R10", "overflow", {31'd0, overflow}, 32'd0);
    rst = 1'b0;

    drive("R4",  0,  3,   5, 1'b0, 32'h0000_0000);
    drive("R1",  0,  0,   9, 1'b0, 32'h0000_0000);
    drive("R1",  1,  0,  -1, 1'b0, 32'h0000_0000);
    drive("R3",  0,  0,  -1, 1'b0, 32'h0000_0000);
    drive("R2",  0, 11,   0, 1'b0, 32'h0000_0000);
    drive("R2",  0, 11,   0, 1'b1, 32'h0000_0000);
    drive("R2",  1, -1,   0, 1'b1, 32'h0000_0000);
    drive("R3",  3, 11,   0, 1'b0, 32'h0000_0000);
    drive("R3",  3, 11,   0, 1'b1, 32'hFFFF_FFFF);
    drive("R3", -32, -32, -32, 1'b0, 32'h0000_0000);
    drive("R2",  2, -5, -20, 1'b1, 32'hA5A5_A5A5);
    drive("R1",  0, 31,  31, 1'b0, 32'h1234_5678);
    drive("R5",  0,  1,   7, 1'b0, 32'h0000_0000);
    drive("R5",  0,  2,   0, 1'b0, 32'h0000_0000);
    drive("R5",  0,  6,   0, 1'b0, 32'h0000_0000);
    drive("R5",  0,  7,   0, 1'b0, 32'h0000_0000);
    drive("R6",  0,  2,   0, 1'b1, 32'h0000_0000);
    drive("R6",  0,  3,   0, 1'b1, 32'h0000_0000);
    drive("R6",  0,  9,   1, 1'b1, 32'h0000_0000);
    drive("R6",  0, 10,   5, 1'b1, 32'h0000_0000);
    drive("R7",  0,  9,   6, 1'b1, 32'h0000_0000);
    drive("R7",  0,  9,   4, 1'b1, 32'h0000_0000);
    drive("R7",  0,  9,   3, 1'b1, 32'h0000_0000);
    drive("R7",  0, 10,   2, 1'b1, 32'h0000_0000);
    drive("R7",  0, 10,   4, 1'b1, 32'h0000_0000);
    drive("R7",  0, 10,   2, 1'b0, 32'h0000_0000);
    drive("R7",  0,  9,   6, 1'b0, 32'h0000_0000);
    drive("R9",  1,  4,   2, 1'b0, 32'hFFFF_FFFF);
    drive("R9",  1,  4,   2, 1'b1, 32'h5A5A_5A5A);
    idle(3);

    // R9: nothing changes while the strobe is low
    check("R9", "hold out_valid", {31'd0, out_valid}, 32'd0);
    check("R9", "hold reg_word", reg_word, last_word);
    check("R9", "hold overflow", {31'd0, overflow}, {31'd0, last_ovf});

    // R8: strobe with gaps gives isolated valid pulses
    drive("R8", 2, 3, 4, 1'b0, 32'h0F0F_0F0F);
    idle(1);
    check("R8", "single pulse", {31'd0, out_valid}, 32'd1);
    idle(1);
    check("R8", "pulse ends", {31'd0, out_valid}, 32'd0);

    for (int i = 0; i < 80; i++) begin
      drive("R2", $signed(IN_W'($urandom)), $signed(IN_W'($urandom)),
            $signed(IN_W'($urandom)), 1'($urandom), $urandom);
      if (i % 7 == 0) idle(1);
    end
    idle(3);
    check("R8", "scoreboard drained", sb_q.size(), 32'd0);
    finish_run();
  end
endmodule